// File: doc/BRIEF.md
# Mixed-Width Column Memory Mapper

This block is one on-chip storage bank built from four 16-bit columns that share a common row depth. Through a single address port it serves two kinds of word: 48-bit instruction words and 32-bit data words. An input selects the width of each access. Storage is numbered as a linear run of 16-bit locations in row-major order: location `s` sits in column `s % 4`, row `s / 4`. A wide word claims three consecutive locations and a narrow word claims two. Because of this numbering, a wide word can wrap from the last column of one row into the first columns of the next. Every column therefore receives its own row index, and all the pieces of a word are written on the same clock edge.

Instruction space starts at location 0 and grows upward. Data space ends at the top of the bank and grows downward to a programmable boundary location, which must be even. The block checks every access against that boundary. An access that would let the two kinds of word share a location is refused: it writes nothing, returns nothing, and raises an error strobe. Reads have a fixed one-cycle latency, and the result is zero-extended onto a 48-bit return bus. The default depth is kept small so that elaboration stays light. Setting `ROW_BITS` to 12 gives the full 4K-deep columns.

Top module: `mixed_col_mem`

## Requirements
- R1: After reset `rdValid`, `accErr` and `cfgErr` are low, `rdData` is zero, and the boundary location is 0, so every location counts as data space and every 48-bit access is refused.
- R2: A 48-bit word at address `a` places its bits [47:32] at location 3a, bits [31:16] at 3a+1 and bits [15:0] at 3a+2, where location `s` maps to column `s % 4` and row `s / 4`. A word whose locations wrap into the next row reads back exactly as it was written.
- R3: A 32-bit word at address `d` places bits [31:16] at location 2d and bits [15:0] at 2d+1. A read returns it on `rdData[31:0]` with `rdData[47:32]` equal to zero.
- R4: An access sampled at clock edge k produces its `rdValid`, `rdData` and `accErr` result during the cycle after edge k only. Whenever `rdValid` is low, `rdData` is zero.
- R5: A pulse on `cfgWr` loads `cfgBound` as the boundary location when the value is even and no larger than the total location count (4·2^ROW_BITS). Any other value leaves the boundary unchanged and raises `cfgErr` for one cycle.
- R6: A 48-bit access is refused when its last location (3a+2) is at or above the boundary location, or lies past the end of the bank.
- R7: A 32-bit access is refused when its first location (2d) lies below the boundary location.
- R8: A refused access writes no location, gives no `rdValid`, and pulses `accErr` for one cycle. An accepted write changes exactly its own two or three locations, and changes them all on one clock edge.
- R9: While `accEn` is low, `accWr` and the other access inputs have no effect on the contents, on `rdValid` or on `accErr`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| accEn | input | 1 | Access request for this cycle |
| accWr | input | 1 | 1 = write, 0 = read |
| accWide | input | 1 | 1 = 48-bit instruction word, 0 = 32-bit data word |
| accAddr | input | ROW_BITS+1 | Word address, counted in words of the selected width |
| wrData | input | 48 | Write word (a 32-bit word uses bits [31:0]) |
| rdData | output | 48 | Read word, zero-extended, zero when not valid |
| rdValid | output | 1 | Read result present this cycle |
| accErr | output | 1 | Previous cycle's access was refused |
| cfgWr | input | 1 | Boundary location write strobe |
| cfgBound | input | ROW_BITS+3 | New boundary location |
| cfgErr | output | 1 | Previous cycle's boundary write was rejected |

## Verification
A corrupted boundary register does not stay hidden. It makes `accErr` disagree with the expected partition on the very next access near the boundary, one cycle after that access is sampled. A wrong row or column choice for one piece of a word is different: it shows up only when a word whose locations wrap across a row edge is read back. Both wrapped instruction words and narrow words that sit next to them are therefore read after the writes that surround them. A refused write that slipped into a column would stay silent until a later legal read of that location. For that reason, each refused write is followed by a read of the locations it targeted.

// File: rtl/mm_pkg.sv
package mm_pkg;

  // Strobes from the rule checker to the column datapath
  typedef struct packed {
    logic wrEn;   // accepted write this cycle
    logic rdEn;   // accepted read this cycle
    logic wide;   // three-piece word when set, two-piece otherwise
  } mmStrobe_t;

endpackage

// File: rtl/mm_column.sv
module mm_column #(
  parameter int ROW_BITS = 8,
  parameter int COL_W    = 16
) (
  input  logic                clk,
  input  logic                we,
  input  logic                re,
  input  logic [ROW_BITS-1:0] rowIdx,
  input  logic [COL_W-1:0]    wrWord,
  output logic [COL_W-1:0]    rdWord
);
  localparam int ROWS = 1 << ROW_BITS;

  logic [COL_W-1:0] store [ROWS];

  always_ff @(posedge clk) begin
    if (we) store[rowIdx] <= wrWord;
    if (re) rdWord <= store[rowIdx];
  end
endmodule

// File: rtl/mm_ctrl.sv
module mm_ctrl
  import mm_pkg::*;
#(
  parameter int ROW_BITS = 8,
  parameter int COL_BITS = 2
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic                             accEn,
  input  logic                             accWr,
  input  logic                             accWide,
  input  logic [ROW_BITS+COL_BITS-2:0]     accAddr,
  input  logic                             cfgWr,
  input  logic [ROW_BITS+COL_BITS:0]       cfgBound,
  output mmStrobe_t                        strb,
  output logic [ROW_BITS+COL_BITS-1:0]     baseSlot,
  output logic                             rdValid,
  output logic                             accErr,
  output logic                             cfgErr
);
  localparam int SLOT_BITS  = ROW_BITS + COL_BITS;
  localparam int BOUND_BITS = SLOT_BITS + 1;
  localparam int EXT_BITS   = SLOT_BITS + 2;
  localparam int SLOTS      = 1 << SLOT_BITS;
  localparam logic [EXT_BITS-1:0]   SLOTS_EXT  = EXT_BITS'(SLOTS);
  localparam logic [BOUND_BITS-1:0] SLOTS_BND  = BOUND_BITS'(SLOTS);
  localparam logic [EXT_BITS-1:0]   EXT_ONE    = EXT_BITS'(1);
  localparam logic [EXT_BITS-1:0]   EXT_TWO    = EXT_BITS'(2);

  logic [BOUND_BITS-1:0] bound;
  logic [EXT_BITS-1:0]   addrExt, firstLoc, lastLoc, boundExt;
  logic                  wideBad, narrowBad, ruleBad, cfgBad;

  // Location span of the requested word
  always_comb begin
    addrExt  = EXT_BITS'(accAddr);
    firstLoc = accWide ? (addrExt + (addrExt << 1)) : (addrExt << 1);
    lastLoc  = firstLoc + (accWide ? EXT_TWO : EXT_ONE);
    boundExt = EXT_BITS'(bound);
  end

  // Partition rules: instructions strictly below the boundary, data at or above
  assign wideBad   = (lastLoc >= boundExt) || (lastLoc >= SLOTS_EXT);
  assign narrowBad = (firstLoc < boundExt);
  assign ruleBad   = accWide ? wideBad : narrowBad;
  assign cfgBad    = cfgBound[0] || (cfgBound > SLOTS_BND);

  assign baseSlot  = firstLoc[SLOT_BITS-1:0];
  assign strb.wrEn = accEn && accWr && !ruleBad;
  assign strb.rdEn = accEn && !accWr && !ruleBad;
  assign strb.wide = accWide;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bound   <= '0;
      rdValid <= 1'b0;
      accErr  <= 1'b0;
      cfgErr  <= 1'b0;
    end else begin
      if (cfgWr && !cfgBad) bound <= cfgBound;
      cfgErr  <= cfgWr && cfgBad;
      rdValid <= strb.rdEn;
      accErr  <= accEn && ruleBad;
    end
  end

  // R4: every read gets exactly one kind of answer in the next cycle
  p_read_answer_r4: assert property (@(posedge clk) disable iff (!rstN)
    (accEn && !accWr) |=> (rdValid != accErr));

  // R5: the boundary always holds a legal even location
  p_bound_legal_r5: assert property (@(posedge clk) disable iff (!rstN)
    (bound[0] == 1'b0) && (bound <= SLOTS_BND));

  // R5: a rejected boundary write leaves the boundary untouched
  p_reject_keeps_r5: assert property (@(posedge clk) disable iff (!rstN)
    cfgErr |-> $stable(bound));

  // R8: a refused access never reached the columns as a write
  p_err_no_write_r8: assert property (@(posedge clk) disable iff (!rstN)
    accErr |-> !$past(strb.wrEn));

  // R9: an idle cycle produces no result strobe
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    !accEn |=> (!rdValid && !accErr));
endmodule

// File: rtl/mm_datapath.sv
module mm_datapath
  import mm_pkg::*;
#(
  parameter int ROW_BITS = 8,
  parameter int COL_BITS = 2,
  parameter int COL_W    = 16
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  mmStrobe_t                    strb,
  input  logic [ROW_BITS+COL_BITS-1:0] baseSlot,
  input  logic [3*COL_W-1:0]           wrData,
  input  logic                         rdValid,
  output logic [3*COL_W-1:0]           rdData
);
  localparam int SLOT_BITS = ROW_BITS + COL_BITS;
  localparam int NCOL      = 1 << COL_BITS;
  localparam logic [COL_BITS-1:0] PIECES_WIDE   = COL_BITS'(3);
  localparam logic [COL_BITS-1:0] PIECES_NARROW = COL_BITS'(2);

  logic [NCOL-1:0]     colWe;
  logic [COL_W-1:0]    colQ [NCOL];
  logic [COL_BITS-1:0] baseColQ;
  logic                wideQ;
  logic [COL_W-1:0]    pieceQ [3];

  // Write steering: each column works out which piece of the word it holds
  for (genvar c = 0; c < NCOL; c++) begin : g_col
    logic [COL_BITS-1:0]  ofs, pieceIdx;
    logic [SLOT_BITS-1:0] slotSum;
    logic                 hit;
    logic [COL_W-1:0]     wrWord;

    always_comb begin
      ofs      = COL_BITS'(c) - baseSlot[COL_BITS-1:0];
      hit      = ofs < (strb.wide ? PIECES_WIDE : PIECES_NARROW);
      slotSum  = baseSlot + SLOT_BITS'(ofs);
      pieceIdx = strb.wide ? ofs : ofs + COL_BITS'(1);
      case (pieceIdx)
        COL_BITS'(0): wrWord = wrData[3*COL_W-1:2*COL_W];
        COL_BITS'(1): wrWord = wrData[2*COL_W-1:COL_W];
        default:      wrWord = wrData[COL_W-1:0];
      endcase
    end

    assign colWe[c] = strb.wrEn && hit;

    mm_column #(.ROW_BITS(ROW_BITS), .COL_W(COL_W)) u_col (
      .clk    (clk),
      .we     (colWe[c]),
      .re     (strb.rdEn && hit),
      .rowIdx (slotSum[SLOT_BITS-1:COL_BITS]),
      .wrWord (wrWord),
      .rdWord (colQ[c])
    );
  end

  always_ff @(posedge clk) begin
    if (strb.rdEn) begin
      baseColQ <= baseSlot[COL_BITS-1:0];
      wideQ    <= strb.wide;
    end
  end

  // Read assembly: piece j comes from the column j places after the first
  for (genvar j = 0; j < 3; j++) begin : g_piece
    logic [COL_BITS-1:0] selCol;
    assign selCol    = baseColQ + COL_BITS'(j);
    assign pieceQ[j] = colQ[selCol];
  end

  always_comb begin
    if (!rdValid)   rdData = '0;
    else if (wideQ) rdData = {pieceQ[0], pieceQ[1], pieceQ[2]};
    else            rdData = {{COL_W{1'b0}}, pieceQ[0], pieceQ[1]};
  end

  // R8: an accepted write touches exactly the columns of one word
  p_whole_word_r8: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrEn |-> ($countones(colWe) == (strb.wide ? 3 : 2)));

  // R8: no column write enable without an accepted write
  p_no_stray_write_r8: assert property (@(posedge clk) disable iff (!rstN)
    !strb.wrEn |-> (colWe == '0));
endmodule

// File: rtl/mixed_col_mem.sv
module mixed_col_mem
  import mm_pkg::*;
#(
  parameter int ROW_BITS = 8,
  parameter int COL_BITS = 2,
  parameter int COL_W    = 16
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic                             accEn,
  input  logic                             accWr,
  input  logic                             accWide,
  input  logic [ROW_BITS+COL_BITS-2:0]     accAddr,
  input  logic [3*COL_W-1:0]               wrData,
  output logic [3*COL_W-1:0]               rdData,
  output logic                             rdValid,
  output logic                             accErr,
  input  logic                             cfgWr,
  input  logic [ROW_BITS+COL_BITS:0]       cfgBound,
  output logic                             cfgErr
);
  mmStrobe_t                      strb;
  logic [ROW_BITS+COL_BITS-1:0]   baseSlot;

  mm_ctrl #(.ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .accEn    (accEn),
    .accWr    (accWr),
    .accWide  (accWide),
    .accAddr  (accAddr),
    .cfgWr    (cfgWr),
    .cfgBound (cfgBound),
    .strb     (strb),
    .baseSlot (baseSlot),
    .rdValid  (rdValid),
    .accErr   (accErr),
    .cfgErr   (cfgErr)
  );

  mm_datapath #(.ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS), .COL_W(COL_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .baseSlot (baseSlot),
    .wrData   (wrData),
    .rdValid  (rdValid),
    .rdData   (rdData)
  );
endmodule

// File: tb/sim_mixed_col_mem.sv
`timescale 1ns/1ps
module sim_mixed_col_mem;
  localparam int ROWB  = 8;
  localparam int COLB  = 2;
  localparam int SLOTS = 1 << (ROWB + COLB);
  localparam int AW    = ROWB + COLB - 1;
  localparam int BW    = ROWB + COLB + 1;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          accEn = 1'b0, accWr = 1'b0, accWide = 1'b0;
  logic [AW-1:0] accAddr = '0;
  logic [47:0]   wrData = '0;
  logic [47:0]   rdData;
  logic          rdValid, accErr, cfgErr;
  logic          cfgWr = 1'b0;
  logic [BW-1:0] cfgBound = '0;

  int nChecks = 0;
  int nErrs = 0;
  int refBound = 0;
  logic [15:0] refMem [SLOTS];

  always #2.5 clk = ~clk;

  mixed_col_mem #(.ROW_BITS(ROWB), .COL_BITS(COLB), .COL_W(16)) u0 (
    .clk(clk), .rstN(rstN), .accEn(accEn), .accWr(accWr), .accWide(accWide),
    .accAddr(accAddr), .wrData(wrData), .rdData(rdData), .rdValid(rdValid),
    .accErr(accErr), .cfgWr(cfgWr), .cfgBound(cfgBound), .cfgErr(cfgErr)
  );

  task automatic chk(input bit ok, input string tag, input logic [47:0] act, input logic [47:0] exp);
    nChecks++;
    if (!ok) begin
      nErrs++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One access, checked against the bench's own placement and partition model
  task automatic doAccess(input bit wide, input bit wr, input int addr, input logic [47:0] data, input string tag);
    int   first = wide ? 3 * addr : 2 * addr;
    int   last  = first + (wide ? 2 : 1);
    bit   bad   = wide ? (last >= refBound || last >= SLOTS) : (first < refBound);
    logic [47:0] exp = '0;
    @(negedge clk);
    accEn = 1'b1; accWr = wr; accWide = wide; accAddr = AW'(addr); wrData = data;
    @(posedge clk); #1;
    chk(accErr == bad, {tag, " error flag"}, 48'(accErr), 48'(bad));
    if (wr) begin
      chk(rdValid == 1'b0, {tag, " no valid on write"}, 48'(rdValid), 48'h0);
      if (!bad) begin
        if (wide) begin
          refMem[first] = data[47:32]; refMem[first+1] = data[31:16]; refMem[first+2] = data[15:0];
        end else begin
          refMem[first] = data[31:16]; refMem[first+1] = data[15:0];
        end
      end
    end else begin
      if (!bad)
        exp = wide ? {refMem[first], refMem[first+1], refMem[first+2]}
                   : {16'h0, refMem[first], refMem[first+1]};
      chk(rdValid == !bad, {tag, " valid"}, 48'(rdValid), 48'(!bad));
      chk(rdData == exp, {tag, " data"}, rdData, exp);
    end
    @(negedge clk);
    accEn = 1'b0; accWr = 1'b0; wrData = '0;
    @(posedge clk); #1;
    chk(!rdValid && !accErr && rdData == '0, "R4 result lasts one cycle",
        {rdData[45:0], rdValid, accErr}, 48'h0);
  endtask

  task automatic doConfig(input int val, input string tag);
    bit bad = (val % 2 != 0) || (val > SLOTS);
    @(negedge clk);
    cfgWr = 1'b1; cfgBound = BW'(val);
    @(posedge clk); #1;
    chk(cfgErr == bad, {tag, " cfgErr"}, 48'(cfgErr), 48'(bad));
    if (!bad) refBound = val;
    @(negedge clk);
    cfgWr = 1'b0;
    @(posedge clk); #1;
    chk(cfgErr == 1'b0, "R5 cfgErr single pulse", 48'(cfgErr), 48'h0);
  endtask

  task automatic testReset;
    chk(!rdValid && !accErr && !cfgErr, "R1 strobes low", {45'h0, rdValid, accErr, cfgErr}, 48'h0);
    chk(rdData == '0, "R1 rdData zero", rdData, 48'h0);
    // boundary 0: a 48-bit read must be refused
    doAccess(1'b1, 1'b0, 0, '0, "R1 reset boundary");
  endtask

  task automatic testInstrSpan;
    doConfig(SLOTS, "R5 load full instruction space");
    doAccess(1'b1, 1'b1, 0,   48'h1111_2222_3333, "R2 write a0");
    doAccess(1'b1, 1'b1, 1,   48'hA1B2_C3D4_E5F6, "R2 write a1 wraps row");
    doAccess(1'b1, 1'b1, 2,   48'hFFFF_0000_FFFF, "R2 write a2");
    doAccess(1'b1, 1'b1, 3,   48'h0123_4567_89AB, "R2 write a3");
    doAccess(1'b1, 1'b1, 4,   48'h4444_5555_6666, "R2 write a4");
    doAccess(1'b1, 1'b1, 340, 48'hDEAD_BEEF_CAFE, "R2 write last word");
    doAccess(1'b1, 1'b0, 0,   '0, "R2 read a0");
    doAccess(1'b1, 1'b0, 1,   '0, "R2 read a1 wraps row");
    doAccess(1'b1, 1'b0, 2,   '0, "R2 read a2");
    doAccess(1'b1, 1'b0, 340, '0, "R2 read last word");
    doAccess(1'b1, 1'b1, 341, 48'h7777_7777_7777, "R6 write past end");
    doAccess(1'b1, 1'b0, 341, '0, "R6 read past end");
  endtask

  task automatic testConfigReject;
    doConfig(7, "R5 odd value rejected");
    doConfig(SLOTS + 2, "R5 oversize value rejected");
    doAccess(1'b1, 1'b0, 340, '0, "R5 boundary unchanged after reject");
  endtask

  task automatic testPartition;
    doConfig(12, "R5 boundary at 12");
    doAccess(1'b1, 1'b0, 3, '0, "R6 word just below boundary");
    doAccess(1'b1, 1'b1, 4, 48'h9999_9999_9999, "R6 refused wide write");
    doAccess(1'b0, 1'b0, 6, '0, "R8 refused wide write left data");
    doAccess(1'b0, 1'b1, 5, 48'h0000_BAD0_BAD1, "R7 refused narrow write");
    doAccess(1'b0, 1'b0, 5, '0, "R7 refused narrow read");
    doAccess(1'b1, 1'b0, 3, '0, "R8 refused narrow write left instruction");
    doAccess(1'b0, 1'b1, 6, 48'h0000_1357_2468, "R7 first data word");
    doAccess(1'b0, 1'b0, 6, '0, "R7 read first data word");
  endtask

  task automatic testDataWords;
    doConfig(0, "R5 boundary at 0");
    doAccess(1'b0, 1'b1, 0,   48'h0000_FFFF_FFFF, "R3 write d0");
    doAccess(1'b0, 1'b1, 1,   48'h0000_0000_0001, "R3 write d1");
    doAccess(1'b0, 1'b1, 2,   48'h0000_A5A5_5A5A, "R3 write d2");
    doAccess(1'b0, 1'b1, 511, 48'h0000_8001_7FFE, "R3 write top word");
    doAccess(1'b0, 1'b0, 0,   '0, "R3 read d0");
    doAccess(1'b0, 1'b0, 1,   '0, "R8 neighbour d1 intact");
    doAccess(1'b0, 1'b0, 2,   '0, "R3 read d2");
    doAccess(1'b0, 1'b0, 511, '0, "R3 read top word");
    doAccess(1'b1, 1'b0, 0,   '0, "R6 wide refused at boundary 0");
  endtask

  task automatic testIdle;
    @(negedge clk);
    accEn = 1'b0; accWr = 1'b1; accWide = 1'b0; accAddr = '0; wrData = 48'h0000_DEAD_DEAD;
    @(posedge clk); #1;
    chk(!rdValid && !accErr, "R9 idle cycle quiet", {46'h0, rdValid, accErr}, 48'h0);
    @(negedge clk);
    accWr = 1'b0; wrData = '0;
    doAccess(1'b0, 1'b0, 0, '0, "R9 idle write had no effect");
  endtask

  initial begin
    #1_000_000;
    nErrs++; nChecks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", nErrs, nChecks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(posedge clk); #1;
    testReset();
    testInstrSpan();
    testConfigReject();
    testPartition();
    testDataWords();
    testIdle();
    $display("Result: errors=%0d of %0d checks", nErrs, nChecks);
    $finish;
  end
endmodule